// File: doc/BRIEF.md
# Audio Status Register and Frame Interrupt

This block is the status and frame-interrupt part of a console-style sound unit. It sits on a small CPU register bus with an address, a write strobe, a read strobe and 8-bit write and read data. The status read collects several inputs into one byte: the active bits from the four channels' length counters, a flag from the sample channel that says bytes remain, and two interrupt flags.

The frame-interrupt flag is set by a one-cycle timing tick. It is set only when the sequencer is in four-step mode and the inhibit bit of the control register is clear. Reading the status register acknowledges the flag. The sample-channel interrupt flag is set by a pulse from outside the block and is cleared only by a write to the status register. An active-low interrupt request is driven low while either flag is set. The block has no knowledge of CPU interrupt masking.

Top module: `snd_status_irq`

## Requirements
- R1: After reset the control register is 0, both flags are clear, `irq_n` is 1 and a status read returns 0x00 when all channel inputs are 0.
- R2: A status read returns bit 7 = sample-interrupt flag, bit 6 = frame-interrupt flag, bit 5 = 0, bit 4 = `sample_bytes_left`, and bits 3..0 = `chan_active` (bit 0 pulse 1, bit 1 pulse 2, bit 2 triangle, bit 3 noise).
- R3: A frame tick sets the frame flag only while control bit 7 (mode) and control bit 6 (inhibit) are both 0. Otherwise the tick leaves the flag unchanged.
- R4: A status read returns the frame flag as it stood before the read and clears it in the same cycle, so a following read returns bit 6 = 0.
- R5: When a frame tick that is allowed to set the flag comes in the same cycle as a status read, the flag ends up set.
- R6: A control write with bit 6 = 1 clears the frame flag at that clock edge. The flag stays clear, ticks included, for as long as inhibit stays 1.
- R7: `irq_n` is 0 exactly when the frame flag or the sample flag is set.
- R8: A `sample_irq_set` pulse sets the sample flag. A status read leaves it set. A status write clears it, and a set pulse in the same cycle as that write wins.
- R9: Reads and writes of the status register never change the control register.
- R10: Control bits 5..0 have no effect.
- R11: `rd_data` is 0x00 unless `rd_en` is high and `addr` selects the status register (address 1; the control register is address 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational in the read cycle |
| frame_tick | input | 1 | One-cycle frame-period pulse |
| sample_irq_set | input | 1 | One-cycle sample-channel interrupt pulse |
| chan_active | input | 4 | Length-counter-active bits of the four channels |
| sample_bytes_left | input | 1 | Sample channel has bytes remaining |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
All 16 channel-active patterns are swept with both states of the bytes-left input. This separates the field placement of the status byte from the flag bits. Every combination of mode and inhibit is tried with different filler values in the ignored control bits. This tells apart a tick that is gated correctly from one that is gated on the wrong bit. Targeted sequences test the timing of set against clear: a read on the tick cycle, back-to-back reads, inhibit while the flag is set, and a sample pulse against a status write. A long pseudo-random stream of mixed bus traffic, ticks and pulses is then compared cycle by cycle with an arithmetic model in the bench.

// File: rtl/snd_status_pkg.sv
package snd_status_pkg;
  localparam int STAT_W = 8;
  localparam int CHAN_N = 4;

  typedef struct packed {
    logic mode;     // 1 = five-step sequencer, no frame interrupt
    logic inhibit;  // 1 = frame interrupt suppressed
  } snd_ctrl_t;

  // Assemble the status byte from its fields.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic              smp_irq,
    input logic              frm_irq,
    input logic              bytes_left,
    input logic [CHAN_N-1:0] active
  );
    return {smp_irq, frm_irq, 1'b0, bytes_left, active};
  endfunction

  // Whether a tick may raise the frame flag under a given control setting.
  function automatic logic tick_allowed(input snd_ctrl_t c);
    return !c.mode && !c.inhibit;
  endfunction
endpackage

// File: rtl/snd_ctrl_reg.sv
module snd_ctrl_reg
  import snd_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [1:0] wbits,   // {mode, inhibit}
  output snd_ctrl_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= snd_ctrl_t'(wbits);
  end

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/snd_frame_flag.sv
module snd_frame_flag
  import snd_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  snd_ctrl_t ctrl,
  input  logic      ctrl_wr_inh,
  input  logic      tick,
  input  logic      status_rd,
  output logic      set_evt,
  output logic      flag
);
  assign set_evt = tick && tick_allowed(ctrl);

  always_ff @(posedge clk) begin
    if (!rst_n)            flag <= 1'b0;
    else if (ctrl_wr_inh)  flag <= 1'b0;
    else if (ctrl.inhibit) flag <= 1'b0;
    else if (set_evt)      flag <= 1'b1;
    else if (status_rd)    flag <= 1'b0;
  end

  // R6
  inh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_inh |=> !flag);
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !ctrl_wr_inh) |=> flag);
  // R4
  read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !set_evt) |=> !flag);
endmodule

// File: rtl/snd_sample_flag.sv
module snd_sample_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic status_wr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (status_wr) flag <= 1'b0;
  end

  // R8
  smp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag);
  // R8
  smp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_pulse && !status_wr) |=> (flag == $past(flag)));
endmodule

// File: rtl/snd_status_irq.sv
module snd_status_irq
  import snd_status_pkg::*;
#(
  parameter int                ADDR_W      = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [STAT_W-1:0]   wr_data,
  output logic [STAT_W-1:0]   rd_data,
  input  logic                frame_tick,
  input  logic                sample_irq_set,
  input  logic [CHAN_N-1:0]   chan_active,
  input  logic                sample_bytes_left,
  output logic                irq_n
);
  logic      status_rd, status_wr, ctrl_wr, ctrl_wr_inh;
  logic      frame_set_evt, frame_flag, sample_flag;
  logic      unused_wbits;
  snd_ctrl_t ctrl_q;

  assign status_rd    = rd_en && (addr == STATUS_ADDR);
  assign status_wr    = wr_en && (addr == STATUS_ADDR);
  assign ctrl_wr      = wr_en && (addr == CTRL_ADDR);
  assign ctrl_wr_inh  = ctrl_wr && wr_data[6];
  assign unused_wbits = ^wr_data[5:0];

  snd_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctrl_wr),
    .wbits (wr_data[7:6]),
    .q     (ctrl_q)
  );

  snd_frame_flag u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl_q),
    .ctrl_wr_inh (ctrl_wr_inh),
    .tick        (frame_tick),
    .status_rd   (status_rd),
    .set_evt     (frame_set_evt),
    .flag        (frame_flag)
  );

  snd_sample_flag u_sample (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (sample_irq_set),
    .status_wr (status_wr),
    .flag      (sample_flag)
  );

  assign rd_data = status_rd
                 ? pack_status(sample_flag, frame_flag, sample_bytes_left, chan_active)
                 : '0;
  assign irq_n   = !(frame_flag || sample_flag);

  // R7
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(frame_set_evt || sample_irq_set));
  // R9
  status_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_rd || status_wr) && !ctrl_wr) |=> $stable(ctrl_q));
endmodule

// File: tb/snd_status_irq_test.sv
module snd_status_irq_test;
  localparam logic [1:0] ST = 2'd1;
  localparam logic [1:0] CT = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       frame_tick = 1'b0, sample_irq_set = 1'b0;
  logic [3:0] chan_active = '0;
  logic       sample_bytes_left = 1'b0;
  logic       irq_n;

  int vectors = 0, fails = 0;
  bit m_mode = 0, m_inh = 0, m_frm = 0, m_smp = 0;

  always #10 clk = ~clk;

  snd_status_irq uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .frame_tick(frame_tick),
    .sample_irq_set(sample_irq_set), .chan_active(chan_active),
    .sample_bytes_left(sample_bytes_left), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input bit w, input bit r, input logic [7:0] d,
                      input bit tk, input bit si, input logic [3:0] act, input bit bl,
                      input string tag);
    bit nf;
    @(negedge clk);
    addr = a; wr_en = w; rd_en = r; wr_data = d;
    frame_tick = tk; sample_irq_set = si; chan_active = act; sample_bytes_left = bl;
    #5;
    check(tag, rd_data, (r && a == ST) ? {m_smp, m_frm, 1'b0, bl, act} : 8'h00);
    check({tag, "/R7 irq"}, {7'b0, irq_n}, {7'b0, !(m_frm || m_smp)});
    @(posedge clk);
    nf = m_frm;
    if (w && a == CT && d[6])             nf = 0;
    else if (m_inh)                        nf = 0;
    else if (tk && !m_mode)                nf = 1;
    else if (r && a == ST)                 nf = 0;
    m_frm = nf;
    if (si)                   m_smp = 1;
    else if (w && a == ST)    m_smp = 0;
    if (w && a == CT) begin m_mode = d[7]; m_inh = d[6]; end
  endtask

  task automatic idle(input string tag);
    step(2'd0, 0, 0, 8'h00, 0, 0, 4'h0, 0, tag);
  endtask
  task automatic rd_st(input string tag);
    step(ST, 0, 1, 8'h00, 0, 0, 4'h0, 0, tag);
  endtask
  task automatic wr_ct(input logic [7:0] d, input string tag);
    step(CT, 1, 0, d, 0, 0, 4'h0, 0, tag);
  endtask
  task automatic tick(input string tag);
    step(2'd0, 0, 0, 8'h00, 1, 0, 4'h0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_st("R1 reset status");
    idle("R1 reset idle");

    // R2 / R11 field sweep
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 2; b++) begin
        step(ST, 0, 1, 8'h00, 0, 0, 4'(c), b[0], "R2 layout");
        step(2'd2, 0, 1, 8'h00, 0, 0, 4'(c), b[0], "R11 other addr");
        step(CT, 0, 1, 8'h00, 0, 0, 4'(c), b[0], "R11 ctrl addr");
        step(ST, 0, 0, 8'h00, 0, 0, 4'(c), b[0], "R11 no strobe");
      end

    // R3 / R10 gating over every mode/inhibit pair with filler bits
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 4; f++) begin
        wr_ct({2'(m), 6'((f * 23 + 5) & 63)}, "R10 ctrl write");
        rd_st("R3 pre-clear");
        tick("R3 tick");
        rd_st("R3 read after tick");
        rd_st("R4 second read");
      end

    // R4 / R5 read vs tick
    wr_ct(8'h00, "R4 enable");
    tick("R4 tick");
    idle("R7 flag held");
    step(ST, 0, 1, 8'h00, 1, 0, 4'h0, 0, "R5 read with tick");
    rd_st("R5 flag survives");
    rd_st("R4 cleared");

    // R6 inhibit clears and holds
    tick("R6 tick");
    wr_ct(8'h40, "R6 inhibit write");
    rd_st("R6 cleared");
    tick("R6 tick while inhibited");
    rd_st("R6 still clear");
    wr_ct(8'h80, "R3 five-step");
    tick("R3 tick mode1");
    rd_st("R3 mode1 no flag");
    wr_ct(8'h00, "R6 release");
    tick("R6 tick after release");
    wr_ct(8'hC0, "R6 write same");
    rd_st("R6 cleared again");

    // R8 sample flag
    wr_ct(8'h3F, "R10 enable with filler");
    step(2'd0, 0, 0, 8'h00, 0, 1, 4'h0, 0, "R8 set pulse");
    rd_st("R8 read keeps");
    rd_st("R8 read keeps 2");
    step(ST, 1, 0, 8'hFF, 0, 0, 4'h0, 0, "R8 status write");
    rd_st("R8 cleared");
    step(2'd0, 0, 0, 8'h00, 0, 1, 4'h0, 0, "R8 set again");
    step(ST, 1, 0, 8'h00, 0, 1, 4'h0, 0, "R8 set wins");
    rd_st("R8 still set");
    step(ST, 1, 0, 8'h00, 0, 0, 4'h0, 0, "R8 clear");

    // R9 status access leaves control alone
    step(ST, 1, 0, 8'hC0, 0, 0, 4'h0, 0, "R9 status write");
    rd_st("R9 status read");
    tick("R9 tick still enabled");
    rd_st("R9 flag set");

    // R7 mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit w, r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = lf[2] & lf[3] & lf[4];
      r = lf[5] & !w;
      step(lf[1:0], w, r, {lf[15] & lf[14], lf[13] & lf[12] & lf[11], lf[10:5]},
           lf[6] & lf[7], lf[8] & lf[9] & lf[10], lf[14:11], lf[0], "R7 mixed");
    end

    idle("R7 end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule